// File: doc/BRIEF.md
# SPI Output Control Register Bank

This block sits behind a 24-bit SPI slave link and holds the control state for sixteen low-side output channels. Each frame carries an 8-bit command code followed by a 16-bit data word with one bit per channel. The block keeps six 16-bit registers:

- channel on/off
- PWM enable
- AND/OR mode select
- fast fault-trip enable
- open-load source enable
- shutdown configuration

It also executes a reset command that clears only part of this state.

For every channel, the on/off, PWM enable and AND/OR bits are combined with one shared PWM input pin to form that channel's gate-drive signal. A channel can follow its on/off bit alone, that bit ANDed with the pin, or that bit ORed with the pin. The SPI lines and the PWM pin are oversampled by the system clock through two-flop synchronizers. A frame is committed only when chip select returns high after exactly 24 clocked bits.

Top module: `spi_out_ctrl`

## Requirements
- R1: Bits are sampled on rising SCLK while CS_N is low, MSB first. The first 8 bits form the command and the last 16 form the data, with data bit i belonging to channel i. Default command codes are 0x01 on/off, 0x02 PWM enable, 0x03 AND/OR mode, 0x04 fault-trip, 0x05 open-load, 0x06 shutdown and 0x07 reset command.
- R2: A register changes only when CS_N rises after exactly 24 SCLK rising edges. Frames of 23 or 25 bits change nothing.
- R3: When a channel's PWM enable bit is 0, its gate equals its on/off bit, whatever the PWM pin and the AND/OR bit are.
- R4: When PWM enable is 1 and AND/OR is 0, the gate is the on/off bit AND the PWM pin.
- R5: When PWM enable is 1 and AND/OR is 1, the gate is the on/off bit OR the PWM pin.
- R6: Asserting rst_n, or holding ext_rst_n low, clears all six registers to 0, so every gate is off.
- R7: The reset command (0x07, data ignored) clears the on/off, PWM enable, AND/OR and fault-trip registers, so every gate is off.
- R8: The reset command leaves the open-load and shutdown registers unchanged.
- R9: Command codes outside the seven listed write nothing.
- R10: A change on pwm_in reaches the gates on the second rising clock edge after it and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, synchronized |
| spi_sclk | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data in |
| pwm_in | input | 1 | Shared PWM input pin |
| gate | output | 16 | Per-channel gate drive |
| trip_en | output | 16 | Fast fault-trip enable register |
| openload_en | output | 16 | Open-load source enable register |
| shutdown_cfg | output | 16 | Shutdown configuration register |

## Verification
A wrong on/off, PWM enable or AND/OR bit appears on that channel's gate as soon as the PWM pin takes the level that separates the modes. The pin level is visible two clocks after it is driven, so each mode is tested with the pin both low and high. A lost or spurious write shows up at the ports within a few clocks after CS_N rises. The three configuration registers are on ports, so a reset command that wrongly clears them is seen directly. A miscounted bit or a byte taken in the wrong order shifts the whole data word, and that error is seen on the first frame that follows.

// File: rtl/spi_oc_pkg.sv
package spi_oc_pkg;

  // Gate drive for one channel from its control bits and the synchronized PWM level.
  function automatic logic gate_mix(input logic on_bit, input logic pwm_en,
                                    input logic or_mode, input logic pwm_lvl);
    logic r;
    if (!pwm_en)      r = on_bit;
    else if (or_mode) r = on_bit | pwm_lvl;
    else              r = on_bit & pwm_lvl;
    return r;
  endfunction

endpackage

// File: rtl/spi_oc_rx.sv
module spi_oc_rx #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  output logic               frame_stb,
  output logic [FRAME_W-1:0] frame
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [2:0]       sclk_q;
  logic [2:0]       cs_q;
  logic [1:0]       mosi_q;
  logic [CNT_W-1:0] bit_cnt;

  // named events
  logic sclk_rise;
  logic cs_rise;
  logic cs_low;

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign cs_rise   = cs_q[1] & ~cs_q[2];
  assign cs_low    = ~cs_q[1];
  assign frame_stb = cs_rise && (bit_cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 3'b000;
      cs_q   <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      frame   <= '0;
    end else if (!cs_low) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      frame <= {frame[FRAME_W-2:0], mosi_q[1]};
      if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_oc_regs.sv
module spi_oc_regs #(
  parameter int          N_CH      = 16,
  parameter int          CMD_W     = 8,
  parameter logic [7:0]  CMD_ONOFF = 8'h01,
  parameter logic [7:0]  CMD_PWMEN = 8'h02,
  parameter logic [7:0]  CMD_ANDOR = 8'h03,
  parameter logic [7:0]  CMD_TRIP  = 8'h04,
  parameter logic [7:0]  CMD_OPENL = 8'h05,
  parameter logic [7:0]  CMD_SHDN  = 8'h06,
  parameter logic [7:0]  CMD_RESET = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_rst_n,
  input  logic             wr_stb,
  input  logic [CMD_W-1:0] wr_cmd,
  input  logic [N_CH-1:0]  wr_data,
  output logic [N_CH-1:0]  on_reg,
  output logic [N_CH-1:0]  pwmen_reg,
  output logic [N_CH-1:0]  ormode_reg,
  output logic [N_CH-1:0]  trip_reg,
  output logic [N_CH-1:0]  openl_reg,
  output logic [N_CH-1:0]  shdn_reg
);
  logic [1:0] ext_q;
  logic       clr;
  logic       known_cmd;
  logic       is_reset;

  assign clr      = ~ext_q[1];
  assign is_reset = (wr_cmd == CMD_W'(CMD_RESET));
  assign known_cmd = (wr_cmd == CMD_W'(CMD_ONOFF)) || (wr_cmd == CMD_W'(CMD_PWMEN)) ||
                     (wr_cmd == CMD_W'(CMD_ANDOR)) || (wr_cmd == CMD_W'(CMD_TRIP))  ||
                     (wr_cmd == CMD_W'(CMD_OPENL)) || (wr_cmd == CMD_W'(CMD_SHDN))  ||
                     is_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 2'b11;
    else        ext_q <= {ext_q[0], ext_rst_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      on_reg     <= '0;
      pwmen_reg  <= '0;
      ormode_reg <= '0;
      trip_reg   <= '0;
      openl_reg  <= '0;
      shdn_reg   <= '0;
    end else if (wr_stb) begin
      if (wr_cmd == CMD_W'(CMD_ONOFF))      on_reg     <= wr_data;
      else if (wr_cmd == CMD_W'(CMD_PWMEN)) pwmen_reg  <= wr_data;
      else if (wr_cmd == CMD_W'(CMD_ANDOR)) ormode_reg <= wr_data;
      else if (wr_cmd == CMD_W'(CMD_TRIP))  trip_reg   <= wr_data;
      else if (wr_cmd == CMD_W'(CMD_OPENL)) openl_reg  <= wr_data;
      else if (wr_cmd == CMD_W'(CMD_SHDN))  shdn_reg   <= wr_data;
      else if (is_reset) begin
        on_reg     <= '0;
        pwmen_reg  <= '0;
        ormode_reg <= '0;
        trip_reg   <= '0;
      end
    end
  end

  // R2
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !clr) |=> $stable({on_reg, pwmen_reg, ormode_reg, trip_reg, openl_reg, shdn_reg}));

  // R7
  reset_cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !clr && is_reset) |=> (on_reg == '0 && pwmen_reg == '0 &&
                                      ormode_reg == '0 && trip_reg == '0));

  // R8
  reset_cmd_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !clr && is_reset) |=> ($stable(openl_reg) && $stable(shdn_reg)));

  // R9
  unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !clr && !known_cmd) |=>
      $stable({on_reg, pwmen_reg, ormode_reg, trip_reg, openl_reg, shdn_reg}));

endmodule

// File: rtl/spi_oc_gate.sv
module spi_oc_gate
  import spi_oc_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_in,
  input  logic [N_CH-1:0] on_reg,
  input  logic [N_CH-1:0] pwmen_reg,
  input  logic [N_CH-1:0] ormode_reg,
  output logic [N_CH-1:0] gate
);
  logic [1:0] pwm_q;
  logic       pwm_lvl;

  assign pwm_lvl = pwm_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 2'b00;
    else        pwm_q <= {pwm_q[0], pwm_in};
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign gate[i] = gate_mix(on_reg[i], pwmen_reg[i], ormode_reg[i], pwm_lvl);
  end

  // R3
  plain_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(on_reg) && $stable(pwmen_reg)) |-> $stable(gate & ~pwmen_reg));

endmodule

// File: rtl/spi_out_ctrl.sv
module spi_out_ctrl #(
  parameter int          N_CH      = 16,
  parameter int          CMD_W     = 8,
  parameter logic [7:0]  CMD_ONOFF = 8'h01,
  parameter logic [7:0]  CMD_PWMEN = 8'h02,
  parameter logic [7:0]  CMD_ANDOR = 8'h03,
  parameter logic [7:0]  CMD_TRIP  = 8'h04,
  parameter logic [7:0]  CMD_OPENL = 8'h05,
  parameter logic [7:0]  CMD_SHDN  = 8'h06,
  parameter logic [7:0]  CMD_RESET = 8'h07
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_rst_n,
  input  logic            spi_sclk,
  input  logic            spi_cs_n,
  input  logic            spi_mosi,
  input  logic            pwm_in,
  output logic [N_CH-1:0] gate,
  output logic [N_CH-1:0] trip_en,
  output logic [N_CH-1:0] openload_en,
  output logic [N_CH-1:0] shutdown_cfg
);
  localparam int FRAME_W = CMD_W + N_CH;

  logic               frame_stb;
  logic [FRAME_W-1:0] frame;
  logic [CMD_W-1:0]   frame_cmd;
  logic [N_CH-1:0]    frame_data;
  logic [N_CH-1:0]    on_reg, pwmen_reg, ormode_reg;

  assign frame_cmd  = frame[FRAME_W-1 -: CMD_W];
  assign frame_data = frame[N_CH-1:0];

  spi_oc_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .frame_stb(frame_stb), .frame(frame)
  );

  spi_oc_regs #(
    .N_CH(N_CH), .CMD_W(CMD_W),
    .CMD_ONOFF(CMD_ONOFF), .CMD_PWMEN(CMD_PWMEN), .CMD_ANDOR(CMD_ANDOR),
    .CMD_TRIP(CMD_TRIP), .CMD_OPENL(CMD_OPENL), .CMD_SHDN(CMD_SHDN),
    .CMD_RESET(CMD_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
    .wr_stb(frame_stb), .wr_cmd(frame_cmd), .wr_data(frame_data),
    .on_reg(on_reg), .pwmen_reg(pwmen_reg), .ormode_reg(ormode_reg),
    .trip_reg(trip_en), .openl_reg(openload_en), .shdn_reg(shutdown_cfg)
  );

  spi_oc_gate #(.N_CH(N_CH)) u_gate (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .on_reg(on_reg), .pwmen_reg(pwmen_reg), .ormode_reg(ormode_reg),
    .gate(gate)
  );

endmodule

// File: tb/spi_out_ctrl_test.sv
module spi_out_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ext_rst_n = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, pwm = 1'b0;
  logic [15:0] gate, trip_en, openload_en, shutdown_cfg;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_on = '0, m_pe = '0, m_ao = '0, m_tr = '0, m_ol = '0, m_sd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_out_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .pwm_in(pwm),
    .gate(gate), .trip_en(trip_en), .openload_en(openload_en), .shutdown_cfg(shutdown_cfg)
  );

  // {cmd, data, pwm level}
  localparam logic [24:0] VEC [NV] = '{
    {8'h01, 16'hA5C3, 1'b0},   // R1 R3
    {8'h02, 16'h00FF, 1'b0},   // R4 pin low
    {8'h03, 16'h0000, 1'b1},   // R4 pin high
    {8'h03, 16'h0F0F, 1'b0},   // R5 pin low
    {8'h03, 16'h0F0F, 1'b1},   // R5 pin high
    {8'h01, 16'h0000, 1'b1},   // R5 OR with on bit clear
    {8'h00, 16'hFFFF, 1'b1},   // R9
    {8'h04, 16'h1234, 1'b0},   // R1 trip
    {8'h05, 16'hBEEF, 1'b0},   // R1 open-load
    {8'h06, 16'h5AA5, 1'b1},   // R1 shutdown
    {8'h01, 16'hFFFF, 1'b1},   // R5
    {8'h07, 16'h1234, 1'b1}    // R7 R8
  };

  function automatic logic [15:0] model_gate(input logic p);
    logic [15:0] g;
    for (int b = 0; b < 16; b++) begin
      case ({m_pe[b], m_ao[b]})
        2'b10:   g[b] = m_on[b] && p;
        2'b11:   g[b] = m_on[b] || p;
        default: g[b] = m_on[b];
      endcase
    end
    return g;
  endfunction

  task automatic model_write(input logic [7:0] c, input logic [15:0] d);
    case (c)
      8'h01: m_on = d;
      8'h02: m_pe = d;
      8'h03: m_ao = d;
      8'h04: m_tr = d;
      8'h05: m_ol = d;
      8'h06: m_sd = d;
      8'h07: begin m_on = '0; m_pe = '0; m_ao = '0; m_tr = '0; end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " gate"}, gate, model_gate(pwm));
    chk({tag, " trip"}, trip_en, m_tr);
    chk({tag, " openload"}, openload_en, m_ol);
    chk({tag, " shutdown"}, shutdown_cfg, m_sd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R6 reset state");

    for (int k = 0; k < NV; k++) begin
      pwm = VEC[k][0];
      send_bits({8'h00, VEC[k][24:1]}, 24);
      model_write(VEC[k][24:17], VEC[k][16:1]);
      check_all($sformatf("R1-table vec %0d", k));
    end
    // after reset command: open-load/shutdown kept, gates off
    chk("R7 gates off", gate, 16'h0000);
    chk("R8 openload kept", openload_en, 16'hBEEF);
    chk("R8 shutdown kept", shutdown_cfg, 16'h5AA5);

    // R2: short and long frames are discarded
    send_bits({8'h00, 8'h01, 16'h3C3C}, 23);
    check_all("R2 23-bit frame");
    send_bits({7'h00, 1'b1, 8'h01, 16'h3C3C}, 25);
    check_all("R2 25-bit frame");
    send_bits({8'h00, 8'h05, 16'h0001}, 25);
    check_all("R2 25-bit openload");

    // R9: code 0xFF ignored
    send_bits({8'h00, 8'hFF, 16'hFFFF}, 24);
    check_all("R9 code FF");

    // R10: pin latency, channel 0 in AND mode with on bit set
    pwm = 1'b0;
    send_bits({8'h00, 8'h01, 16'h0001}, 24); model_write(8'h01, 16'h0001);
    send_bits({8'h00, 8'h02, 16'h0001}, 24); model_write(8'h02, 16'h0001);
    chk("R10 pin low", gate, 16'h0000);
    pwm = 1'b1;
    @(posedge clk); #1;
    chk("R10 after one edge", gate, 16'h0000);
    @(posedge clk); #1;
    chk("R10 after two edges", gate, 16'h0001);

    // R6: external reset pin clears every register
    send_bits({8'h00, 8'h05, 16'h00F0}, 24);
    send_bits({8'h00, 8'h04, 16'h0F00}, 24);
    @(negedge clk); ext_rst_n = 1'b0;
    repeat (5) @(negedge clk); ext_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_on = '0; m_pe = '0; m_ao = '0; m_tr = '0; m_ol = '0; m_sd = '0;
    check_all("R6 ext pin");
    chk("R6 gate off", gate, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule